// File: doc/BRIEF.md
# Serial Peripheral FIFO Control and Status

This block holds the transmit and receive byte queues of a serial peripheral controller, together with the two registers that software uses to steer them. The serial shift engine pops bytes from the transmit queue and pushes received bytes into the receive queue. Software reaches both queues through one data port on a simple single-cycle bus slave. Each queue's fill level is compared against a programmable trigger level. The results drive sticky status bits and DMA request lines.

Software can clear either queue's pointers and level with a control bit that clears itself. Two test modes hand the engine-side port of a queue to the bus, so that a queue can be written and read back entirely from software. Status bits are sticky and write-one-to-clear. A bit whose condition still holds is raised again on the following cycle.

Top module: `spi_fifo_ctl`

## Requirements
- R1: After reset the control register (offset 0x18) reads 0x00400001, both queues are empty and every status bit is 0 until the first clock edge after reset.
- R2: The control register holds rx trigger [7:0], rx DMA enable [8], rx test [14], tx trigger [23:16], tx DMA enable [24] and tx test [30]. Bits 31 and 15 are reset strobes and all other bits read 0.
- R3: Each queue is 64 entries of 8 bits in first-in first-out order. A bus write to offset 0x20 pushes the transmit queue, and a bus read of offset 0x20 returns and pops the receive queue head. The engine sees the transmit head on eng_tx_data, and the value is 0 when the queue is empty.
- R4: A push to a full queue and a pop from an empty queue are dropped. Each one sets a sticky flag: rx overflow [2], rx underflow [3], tx overflow [6] or tx underflow [7] of the status register at 0x1C. eng_rx_full is high when the receive queue holds 64 entries.
- R5: Writing 1 to control bit 31 empties the transmit queue on the following clock edge. The bit reads 1 for exactly one cycle and then 0. Writing 0 to it leaves the queue untouched.
- R6: Control bit 15 does the same for the receive queue.
- R7: Status bit 4 is set when the transmit level is at most the tx trigger. tx_dreq is high exactly when bit 24 is 1 and the transmit level is at most the tx trigger.
- R8: Status bit 0 is set when the receive level is at least the rx trigger. rx_dreq is high exactly when bit 8 is 1 and the receive level is at least the rx trigger.
- R9: Status bit 1 is set when the receive queue is empty, and bit 5 is set when the transmit queue is empty.
- R10: Writing 1 to a status bit clears it. If its setting event occurs in the same cycle, the bit stays set.
- R11: With tx test set, bus reads of 0x20 return and pop the transmit head, and engine pops are ignored.
- R12: With rx test set and tx test clear, bus writes of 0x20 push the receive queue, and engine pushes are ignored. With both set, tx test governs and writes go to the transmit queue.
- R13: The status register shows the receive level in [14:8] and the transmit level in [22:16]. Its other unlisted bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 8 | Transmit head |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive queue full |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
A write-one-to-clear of a status bit can land in the same cycle as the event that sets that bit. The bench forces this in two ways. First, it clears the rx-ready bit while the receive level stays above the trigger. Second, it drives an engine push into a full receive queue in the same cycle as the bus write that clears the overflow flag. The behavioural queue model applies set-over-clear independently, and the following status read must show the bit still set.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h18;
  localparam logic [7:0] ADDR_STAT = 8'h1C;
  localparam logic [7:0] ADDR_DATA = 8'h20;

  localparam int ST_RX_RDY = 0;
  localparam int ST_RX_EMP = 1;
  localparam int ST_RX_OVF = 2;
  localparam int ST_RX_UDF = 3;
  localparam int ST_TX_RDY = 4;
  localparam int ST_TX_EMP = 5;
  localparam int ST_TX_OVF = 6;
  localparam int ST_TX_UDF = 7;

  typedef struct packed {
    logic       tx_test;
    logic       tx_dma;
    logic [7:0] tx_trig;
    logic       rx_test;
    logic       rx_dma;
    logic [7:0] rx_trig;
  } ctrl_t;

  function automatic logic tx_low(input logic [7:0] lvl, input logic [7:0] trig);
    return lvl <= trig;
  endfunction

  function automatic logic rx_high(input logic [7:0] lvl, input logic [7:0] trig);
    return lvl >= trig;
  endfunction

  function automatic logic [31:0] pack_ctrl(input ctrl_t c, input logic txr, input logic rxr);
    return {txr, c.tx_test, 5'b0, c.tx_dma, c.tx_trig,
            rxr, c.rx_test, 5'b0, c.rx_dma, c.rx_trig};
  endfunction
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_rej,
  output logic          pop_rej
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign push_ok  = push && !full && !clr;
  assign pop_ok   = pop && !empty && !clr;
  assign push_rej = push && full && !clr;
  assign pop_rej  = pop && empty && !clr;
  assign head     = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full && $stable(wr_ptr)) else $error("overflow"); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clr |=> empty && $stable(rd_ptr)) else $error("underflow"); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty) else $error("clear"); // R5
  AST_FIFO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok |=> level == $past(level) + 1'b1) else $error("step"); // R3
endmodule

// File: rtl/sfc_w1c.sv
module sfc_w1c #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]) else $error("set lost"); // R10
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !q[i]) else $error("clear lost"); // R10
  end
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import sfc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_empty,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  output logic          eng_rx_full,
  output logic          tx_dreq,
  output logic          rx_dreq
);
  ctrl_t ctrl_q;
  logic  tx_rst_q, rx_rst_q;

  // named bus events
  logic ctrl_wr, stat_wr, data_wr, data_rd, rx_test_eff;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_STAT);
  assign data_wr = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
  assign rx_test_eff = ctrl_q.rx_test && !ctrl_q.tx_test;

  // queue port steering
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic [DW-1:0] rx_din, tx_head, rx_head;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_ovf_ev, tx_udf_ev, rx_ovf_ev, rx_udf_ev;

  assign tx_push = data_wr && !rx_test_eff;
  assign tx_pop  = ctrl_q.tx_test ? data_rd : eng_tx_pop;
  assign rx_push = rx_test_eff ? data_wr : eng_rx_push;
  assign rx_pop  = data_rd && !ctrl_q.tx_test;
  assign rx_din  = rx_test_eff ? bus_wdata[DW-1:0] : eng_rx_data;

  sfc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(tx_rst_q), .push(tx_push), .pop(tx_pop),
    .din(bus_wdata[DW-1:0]), .head(tx_head), .level(tx_lvl), .full(tx_full),
    .empty(tx_empty), .push_rej(tx_ovf_ev), .pop_rej(tx_udf_ev));

  sfc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst_q), .push(rx_push), .pop(rx_pop),
    .din(rx_din), .head(rx_head), .level(rx_lvl), .full(rx_full),
    .empty(rx_empty), .push_rej(rx_ovf_ev), .pop_rej(rx_udf_ev));

  // watermark compare
  logic [7:0] tx_lvl8, rx_lvl8;
  logic       tx_low_now, rx_high_now;
  assign tx_lvl8     = 8'(tx_lvl);
  assign rx_lvl8     = 8'(rx_lvl);
  assign tx_low_now  = tx_low(tx_lvl8, ctrl_q.tx_trig);
  assign rx_high_now = rx_high(rx_lvl8, ctrl_q.rx_trig);

  // sticky status
  logic [7:0] st_set, st_clr, st_q;
  always_comb begin
    st_set            = '0;
    st_set[ST_RX_RDY] = rx_high_now;
    st_set[ST_RX_EMP] = rx_empty;
    st_set[ST_RX_OVF] = rx_ovf_ev;
    st_set[ST_RX_UDF] = rx_udf_ev;
    st_set[ST_TX_RDY] = tx_low_now;
    st_set[ST_TX_EMP] = tx_empty;
    st_set[ST_TX_OVF] = tx_ovf_ev;
    st_set[ST_TX_UDF] = tx_udf_ev;
  end
  assign st_clr = stat_wr ? bus_wdata[7:0] : 8'h00;

  sfc_w1c #(.N(8)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .q(st_q));

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '{tx_test: 1'b0, tx_dma: 1'b0, tx_trig: 8'h40,
                    rx_test: 1'b0, rx_dma: 1'b0, rx_trig: 8'h01};
      tx_rst_q <= 1'b0;
      rx_rst_q <= 1'b0;
    end else begin
      tx_rst_q <= ctrl_wr && bus_wdata[31];
      rx_rst_q <= ctrl_wr && bus_wdata[15];
      if (ctrl_wr) begin
        ctrl_q.tx_test <= bus_wdata[30];
        ctrl_q.tx_dma  <= bus_wdata[24];
        ctrl_q.tx_trig <= bus_wdata[23:16];
        ctrl_q.rx_test <= bus_wdata[14];
        ctrl_q.rx_dma  <= bus_wdata[8];
        ctrl_q.rx_trig <= bus_wdata[7:0];
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata = pack_ctrl(ctrl_q, tx_rst_q, rx_rst_q);
        ADDR_STAT: bus_rdata = (32'(tx_lvl) << 16) | (32'(rx_lvl) << 8) | 32'(st_q);
        ADDR_DATA: bus_rdata = 32'(ctrl_q.tx_test ? tx_head : rx_head);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign eng_tx_data  = tx_head;
  assign eng_tx_empty = tx_empty;
  assign eng_rx_full  = rx_full;
  assign tx_dreq      = ctrl_q.tx_dma && tx_low_now;
  assign rx_dreq      = ctrl_q.rx_dma && rx_high_now;

  AST_TX_RST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_q && !ctrl_wr |=> !tx_rst_q) else $error("tx rst"); // R5
  AST_RX_RST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_q && !ctrl_wr |=> !rx_rst_q) else $error("rx rst"); // R6
  AST_TX_DREQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> ctrl_q.tx_dma && (tx_lvl8 <= ctrl_q.tx_trig)) else $error("tx dreq"); // R7
  AST_RX_RDY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl8 >= ctrl_q.rx_trig |=> st_q[ST_RX_RDY]) else $error("rx rdy"); // R8
  AST_TEST_ENGINE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.tx_test && eng_tx_pop && !data_rd && !tx_rst_q && !tx_push |=> $stable(tx_lvl))
    else $error("engine pop in test"); // R11
endmodule

// File: tb/tb_spi_fifo_ctl.sv
`timescale 1ns/1ps
module tb_spi_fifo_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel, bus_wr, eng_tx_pop, eng_rx_push;
  logic [7:0] bus_addr, eng_rx_data, eng_tx_data;
  logic [31:0] bus_wdata, bus_rdata;
  logic eng_tx_empty, eng_rx_full, tx_dreq, rx_dreq;

  int checks = 0, errors = 0;
  bit done = 0;
  string rtag = "";

  // behavioural model
  byte unsigned txq[$], rxq[$];
  logic m_tx_test = 0, m_tx_dma = 0, m_rx_test = 0, m_rx_dma = 0, m_txr = 0, m_rxr = 0;
  logic [7:0] m_tx_trig = 8'h40, m_rx_trig = 8'h01, m_st = 8'h00;

  always #4 clk = ~clk;

  spi_fifo_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h18: return {m_txr, m_tx_test, 5'b0, m_tx_dma, m_tx_trig,
                     m_rxr, m_rx_test, 5'b0, m_rx_dma, m_rx_trig};
      8'h1C: return {9'b0, 7'(txq.size()), 1'b0, 7'(rxq.size()), m_st};
      8'h20: begin
        if (m_tx_test) return (txq.size() > 0) ? 32'(txq[0]) : 32'h0;
        return (rxq.size() > 0) ? 32'(rxq[0]) : 32'h0;
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive_idle();
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
  endtask

  // one clock: check read, advance model, compare engine-side outputs
  task automatic step();
    logic dwr, drd, cwr, swr, teff, txpush, txpop, rxpush, rxpop;
    logic [7:0] setv, clrv, rxd;
    int txn, rxn;
    #1;
    if (bus_sel && !bus_wr) chk(rtag, bus_rdata, m_read(bus_addr));
    dwr = bus_sel && bus_wr && bus_addr == 8'h20;
    drd = bus_sel && !bus_wr && bus_addr == 8'h20;
    cwr = bus_sel && bus_wr && bus_addr == 8'h18;
    swr = bus_sel && bus_wr && bus_addr == 8'h1C;
    teff = m_rx_test && !m_tx_test;
    txpush = dwr && !teff;
    txpop = m_tx_test ? drd : eng_tx_pop;
    rxpush = teff ? dwr : eng_rx_push;
    rxpop = drd && !m_tx_test;
    rxd = teff ? bus_wdata[7:0] : eng_rx_data;
    txn = txq.size(); rxn = rxq.size();
    setv[0] = rxn >= int'(m_rx_trig);
    setv[1] = rxn == 0;
    setv[2] = rxpush && rxn == 64 && !m_rxr;
    setv[3] = rxpop && rxn == 0 && !m_rxr;
    setv[4] = txn <= int'(m_tx_trig);
    setv[5] = txn == 0;
    setv[6] = txpush && txn == 64 && !m_txr;
    setv[7] = txpop && txn == 0 && !m_txr;
    clrv = swr ? bus_wdata[7:0] : 8'h00;
    @(posedge clk);
    m_st = (m_st & ~clrv) | setv;
    if (m_txr) txq.delete();
    else begin
      if (txpop && txn > 0) void'(txq.pop_front());
      if (txpush && txn < 64) txq.push_back(bus_wdata[7:0]);
    end
    if (m_rxr) rxq.delete();
    else begin
      if (rxpop && rxn > 0) void'(rxq.pop_front());
      if (rxpush && rxn < 64) rxq.push_back(rxd);
    end
    m_txr = cwr && bus_wdata[31];
    m_rxr = cwr && bus_wdata[15];
    if (cwr) begin
      m_tx_test = bus_wdata[30]; m_tx_dma = bus_wdata[24]; m_tx_trig = bus_wdata[23:16];
      m_rx_test = bus_wdata[14]; m_rx_dma = bus_wdata[8];  m_rx_trig = bus_wdata[7:0];
    end
    @(negedge clk);
    chk("R3 eng_tx_data", 32'(eng_tx_data), (txq.size() > 0) ? 32'(txq[0]) : 32'h0);
    chk("R3 eng_tx_empty", 32'(eng_tx_empty), 32'(txq.size() == 0));
    chk("R4 eng_rx_full", 32'(eng_rx_full), 32'(rxq.size() == 64));
    chk("R7 tx_dreq", 32'(tx_dreq), 32'(m_tx_dma && txq.size() <= int'(m_tx_trig)));
    chk("R8 rx_dreq", 32'(rx_dreq), 32'(m_rx_dma && rxq.size() >= int'(m_rx_trig)));
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    drive_idle(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(); drive_idle();
  endtask

  task automatic brd(input logic [7:0] a, input string tag);
    drive_idle(); bus_sel = 1; bus_wr = 0; bus_addr = a; rtag = tag;
    step(); drive_idle();
  endtask

  task automatic epush(input logic [7:0] d);
    drive_idle(); eng_rx_push = 1; eng_rx_data = d; step(); drive_idle();
  endtask

  task automatic epop();
    drive_idle(); eng_tx_pop = 1; step(); drive_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    brd(8'h18, "R1 ctrl reset");
    brd(8'h1C, "R1 R9 status after reset");
    // R2 layout readback
    bwr(8'h18, 32'h01020103);
    brd(8'h18, "R2 ctrl readback");
    // R3 tx order, R7 watermark
    for (int i = 0; i < 5; i++) bwr(8'h20, 32'(8'h10 + i));
    brd(8'h1C, "R7 R13 status tx level 5");
    for (int i = 0; i < 5; i++) epop();
    epop();  // R4 underflow
    brd(8'h1C, "R4 tx underflow flag");
    // R3 rx fill and R4 overflow, R8 dreq
    for (int i = 0; i < 65; i++) epush(8'(8'h80 + i));
    brd(8'h1C, "R4 R8 rx overflow and ready");
    for (int i = 0; i < 3; i++) brd(8'h20, "R3 rx data order");
    // R10 collision: clear all while rx_rdy condition holds
    bwr(8'h1C, 32'h000000FF);
    brd(8'h1C, "R10 set wins over clear");
    epush(8'h01); epush(8'h02); epush(8'h03);
    drive_idle(); bus_sel = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 32'h04;
    eng_rx_push = 1; eng_rx_data = 8'hEE; step(); drive_idle();
    brd(8'h1C, "R10 overflow set while cleared");
    bwr(8'h1C, 32'h000000FF);
    brd(8'h1C, "R10 clear takes when idle");
    // R6 rx reset
    bwr(8'h18, 32'h01028103);
    brd(8'h18, "R6 reset bit visible one cycle");
    brd(8'h1C, "R6 rx emptied");
    brd(8'h18, "R6 reset bit self-cleared");
    brd(8'h20, "R4 rx read when empty");
    brd(8'h1C, "R4 R9 rx underflow and empty");
    // R5 tx reset
    for (int i = 0; i < 3; i++) bwr(8'h20, 32'(8'h30 + i));
    bwr(8'h18, 32'h01020103);
    brd(8'h1C, "R5 writing zero keeps tx");
    bwr(8'h18, 32'h81020103);
    brd(8'h18, "R5 reset bit visible");
    brd(8'h1C, "R5 tx emptied");
    // R11 tx test
    bwr(8'h20, 32'h000000A1); bwr(8'h20, 32'h000000A2);
    bwr(8'h18, 32'h41020103);
    epop();
    brd(8'h1C, "R11 engine pop ignored");
    brd(8'h20, "R11 bus reads tx head");
    brd(8'h20, "R11 bus reads next tx");
    // R12 rx test
    bwr(8'h18, 32'h01024103);
    bwr(8'h20, 32'h0000005C);
    epush(8'h77);
    brd(8'h1C, "R12 rx test level");
    brd(8'h20, "R12 rx test readback");
    bwr(8'h18, 32'h41024103);
    bwr(8'h20, 32'h00000099);
    brd(8'h1C, "R12 tx test priority");
    brd(8'h44, "R13 unmapped offset reads zero");
    brd(8'h1C, "R13 final status");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule